// File: doc/BRIEF.md
# Split-Register 64-Bit Periodic Timer

This block is a 64-bit interval timer reached through a plain 32-bit register bus with single-cycle write and read strobes. Software sets a 64-bit period as two 32-bit halves, picks a prescale divider and a run mode, and starts the counter. The counter advances once per prescaled tick. When the 64-bit count equals the period, a pending flag is raised and the counter either wraps to zero and keeps going (continuous mode) or halts (one-shot mode).

A start-on-write mode makes a write to the low period half start or restart the counter. In that mode, writes to the count halves while the counter runs load new count values. A 64-bit count is read coherently by reading the low half first and then the high half. The pending flag is cleared by reading it. An enable register gates the flag onto the interrupt pin.

Top module: `split_period_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irqOut` is low.
- R2: Writing 1 to bit 0 of the control register (word 0) sets the count to 0 and starts the counter. The count then increments by one on each tick. This has priority over every other count update in the same cycle.
- R3: The mode register (word 1) bits 7:4 hold a prescale value p. While running, a tick occurs on every (p+1)th clock, counted from the start.
- R4: On a tick where the 64-bit count equals {period high (word 3), period low (word 2)}, the pending flag sets. In continuous mode (mode bit 0 = 1), the count returns to 0 and counting goes on.
- R5: In one-shot mode (mode bit 0 = 0), the same match sets the count to 0 and stops the counter. A later start runs it again.
- R6: With start-on-write set (mode bit 1 = 1), a write to word 2 starts or restarts the counter from 0. A write to word 3 does not.
- R7: With start-on-write set and the counter running, writes to word 4 or word 5 load the low or high count half. These writes are ignored when the counter is stopped or start-on-write is clear.
- R8: With start-on-write clear, period writes only store their value. They neither start the counter nor disturb a stopped count.
- R9: Reading word 4 returns the live low count and latches the live high count. Reading word 5 returns that latched high half.
- R10: Reading the status register (word 6) returns the pending flag in bit 0 and clears it. A match in the same cycle leaves the flag set.
- R11: `irqOut` equals the pending flag AND bit 0 of the enable register (word 7). The flag still sets while that bit is 0.
- R12: With start-on-write set and a short period, writing the high half, then the low half, then start produces two separate expirations: one from the low-half write and one from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; read side effects occur at the clock edge |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address (combinational) |
| irqOut | output | 1 | Gated interrupt |

## Verification
The counter is driven with periods of 0, 1, 3 and one with a non-zero high half, under prescale values 0 and 2. This separates the match compare from the wrap logic and the divider phase. One-shot and continuous runs are compared to show the stop-versus-wrap choice. Start-on-write sequences are run with the mode bit both set and clear, which shows whether period and count writes act on the counter or only store. A status read that lands on a matching tick shows set-wins ordering, and a low/high count read across a carry shows the shadow latch.

// File: rtl/split_period_timer_pkg.sv
package split_period_timer_pkg;
  localparam int DataW = 32;
  localparam int CountW = 2 * DataW;
  localparam int AddrW = 3;
  localparam int PresW = 4;

  localparam logic [AddrW-1:0] AddrCtrl   = 3'd0;
  localparam logic [AddrW-1:0] AddrMode   = 3'd1;
  localparam logic [AddrW-1:0] AddrPerLo  = 3'd2;
  localparam logic [AddrW-1:0] AddrPerHi  = 3'd3;
  localparam logic [AddrW-1:0] AddrCntLo  = 3'd4;
  localparam logic [AddrW-1:0] AddrCntHi  = 3'd5;
  localparam logic [AddrW-1:0] AddrStatus = 3'd6;
  localparam logic [AddrW-1:0] AddrEnable = 3'd7;

  typedef struct packed {
    logic startReq;
    logic loadLo;
    logic loadHi;
    logic latchShadow;
  } ctrlStrobes_t;
endpackage

// File: rtl/split_period_timer_datapath.sv
module split_period_timer_datapath
  import split_period_timer_pkg::*;
#(
  parameter int HalfW = DataW,
  parameter int PrescW = PresW,
  localparam int FullW = 2 * HalfW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [HalfW-1:0]  wrData,
  input  logic [FullW-1:0]  period,
  input  logic [PrescW-1:0] prescale,
  input  logic              continuous,
  output logic [FullW-1:0]  count,
  output logic [HalfW-1:0]  shadowHi,
  output logic              matchPulse,
  output logic              running
);
  logic [PrescW-1:0] divCnt;
  logic tick;
  logic anyLoad;

  assign tick = running && (divCnt == prescale);
  assign anyLoad = strobes.loadLo || strobes.loadHi;
  assign matchPulse = tick && (count == period) && !strobes.startReq && !anyLoad;

  // prescale divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobes.startReq) begin
      divCnt <= '0;
    end else if (running) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  // 64-bit counter and run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      running <= 1'b0;
    end else if (strobes.startReq) begin
      count   <= '0;
      running <= 1'b1;
    end else if (anyLoad) begin
      if (strobes.loadLo) count[HalfW-1:0] <= wrData;
      if (strobes.loadHi) count[FullW-1:HalfW] <= wrData;
    end else if (tick) begin
      if (count == period) begin
        count   <= '0;
        running <= continuous;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // shadow of the high half for coherent reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowHi <= '0;
    else if (strobes.latchShadow) shadowHi <= count[FullW-1:HalfW];
  end

  // R2: a start always leaves the count at zero and running
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startReq |=> (count == '0) && running);

  // R5: one-shot match halts the counter
  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !continuous) |=> !running && (count == '0));

  // R4: continuous match wraps and keeps running
  a_r4_cont_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && continuous) |=> running && (count == '0));

  // R3: with a nonzero prescale, ticks are never back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && prescale != '0 && $stable(prescale) && !strobes.startReq) |=> !tick);
endmodule

// File: rtl/split_period_timer_ctrl.sv
module split_period_timer_ctrl
  import split_period_timer_pkg::*;
#(
  parameter int HalfW = DataW,
  parameter int AW = AddrW,
  parameter int PrescW = PresW,
  localparam int FullW = 2 * HalfW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [AW-1:0]     busAddr,
  input  logic [HalfW-1:0]  busWdata,
  output logic [HalfW-1:0]  busRdata,
  output logic              irqOut,
  output ctrlStrobes_t      strobes,
  output logic [FullW-1:0]  period,
  output logic [PrescW-1:0] prescale,
  output logic              continuous,
  input  logic [FullW-1:0]  count,
  input  logic [HalfW-1:0]  shadowHi,
  input  logic              matchPulse,
  input  logic              running
);
  logic startOnWrite;
  logic enableBit;
  logic pendFlag;
  logic [HalfW-1:0] perLo, perHi;
  logic wrCtrl, wrMode, wrPerLo, wrPerHi, wrCntLo, wrCntHi, wrEnable;
  logic rdStatus, rdCntLo;

  assign wrCtrl   = busWe && (busAddr == AddrCtrl);
  assign wrMode   = busWe && (busAddr == AddrMode);
  assign wrPerLo  = busWe && (busAddr == AddrPerLo);
  assign wrPerHi  = busWe && (busAddr == AddrPerHi);
  assign wrCntLo  = busWe && (busAddr == AddrCntLo);
  assign wrCntHi  = busWe && (busAddr == AddrCntHi);
  assign wrEnable = busWe && (busAddr == AddrEnable);
  assign rdStatus = busRe && (busAddr == AddrStatus);
  assign rdCntLo  = busRe && (busAddr == AddrCntLo);

  always_comb begin
    strobes = '0;
    strobes.startReq    = (wrCtrl && busWdata[0]) || (wrPerLo && startOnWrite);
    strobes.loadLo      = wrCntLo && startOnWrite && running;
    strobes.loadHi      = wrCntHi && startOnWrite && running;
    strobes.latchShadow = rdCntLo;
  end

  assign period = {perHi, perLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perLo        <= '0;
      perHi        <= '0;
      continuous   <= 1'b0;
      startOnWrite <= 1'b0;
      prescale     <= '0;
      enableBit    <= 1'b0;
    end else begin
      if (wrPerLo) perLo <= busWdata;
      if (wrPerHi) perHi <= busWdata;
      if (wrMode) begin
        continuous   <= busWdata[0];
        startOnWrite <= busWdata[1];
        prescale     <= busWdata[4 +: PrescW];
      end
      if (wrEnable) enableBit <= busWdata[0];
    end
  end

  // pending flag: a new match wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendFlag <= 1'b0;
    else if (matchPulse) pendFlag <= 1'b1;
    else if (rdStatus) pendFlag <= 1'b0;
  end

  assign irqOut = pendFlag && enableBit;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      AddrMode:   begin
        busRdata[0] = continuous;
        busRdata[1] = startOnWrite;
        busRdata[4 +: PrescW] = prescale;
      end
      AddrPerLo:  busRdata = perLo;
      AddrPerHi:  busRdata = perHi;
      AddrCntLo:  busRdata = count[HalfW-1:0];
      AddrCntHi:  busRdata = shadowHi;
      AddrStatus: busRdata[0] = pendFlag;
      AddrEnable: busRdata[0] = enableBit;
      default:    busRdata = '0;
    endcase
  end

  // R10: a match always leaves the flag visible next cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> pendFlag);

  // R10: a status read with no match clears the flag
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !matchPulse) |=> !pendFlag);

  // R8: with start-on-write clear, period writes never start the counter
  a_r8_no_start: assert property (@(posedge clk) disable iff (!rstN)
    ((wrPerLo || wrPerHi) && !startOnWrite && !running) |=> !running);
endmodule

// File: rtl/split_period_timer.sv
module split_period_timer
  import split_period_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [AddrW-1:0] busAddr,
  input  logic [DataW-1:0] busWdata,
  output logic [DataW-1:0] busRdata,
  output logic             irqOut
);
  ctrlStrobes_t strobes;
  logic [CountW-1:0] period, count;
  logic [PresW-1:0] prescale;
  logic continuous, matchPulse, running;
  logic [DataW-1:0] shadowHi;

  split_period_timer_ctrl #(.HalfW(DataW), .AW(AddrW), .PrescW(PresW)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .strobes(strobes),
    .period(period), .prescale(prescale), .continuous(continuous), .count(count),
    .shadowHi(shadowHi), .matchPulse(matchPulse), .running(running)
  );

  split_period_timer_datapath #(.HalfW(DataW), .PrescW(PresW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWdata), .period(period),
    .prescale(prescale), .continuous(continuous), .count(count), .shadowHi(shadowHi),
    .matchPulse(matchPulse), .running(running)
  );
endmodule

// File: tb/split_period_timer_tb_top.sv
module split_period_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  split_period_timer dut_i (.clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  // behavioural reference model
  logic [63:0] mCnt = '0, mPer = '0;
  logic [31:0] mShadow = '0;
  int mDiv = 0, mPres = 0;
  bit mRun = 0, mCont = 0, mSow = 0, mFlag = 0, mEn = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mPer = '0; mShadow = '0; mDiv = 0; mPres = 0;
      mRun = 0; mCont = 0; mSow = 0; mFlag = 0; mEn = 0;
    end else begin
      bit start, ldLo, ldHi, tick, hit;
      start = busWe && ((busAddr == 0 && busWdata[0]) || (busAddr == 2 && mSow));
      ldLo = busWe && busAddr == 4 && mSow && mRun;
      ldHi = busWe && busAddr == 5 && mSow && mRun;
      tick = mRun && (mDiv == mPres);
      hit = 0;
      if (busRe && busAddr == 4) mShadow = mCnt[63:32];
      if (busRe && busAddr == 6) mFlag = 0;
      if (start) begin
        mCnt = 0; mRun = 1; mDiv = 0;
      end else begin
        if (mRun) mDiv = tick ? 0 : mDiv + 1;
        if (ldLo || ldHi) begin
          if (ldLo) mCnt[31:0] = busWdata;
          if (ldHi) mCnt[63:32] = busWdata;
        end else if (tick) begin
          if (mCnt == mPer) begin
            hit = 1; mCnt = 0; mRun = mCont;
          end else mCnt = mCnt + 1;
        end
      end
      if (hit) mFlag = 1;
      if (busWe) begin
        case (busAddr)
          3'd1: begin mCont = busWdata[0]; mSow = busWdata[1]; mPres = int'(busWdata[7:4]); end
          3'd2: mPer[31:0] = busWdata;
          3'd3: mPer[63:32] = busWdata;
          3'd7: mEn = busWdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [2:0] a);
    case (a)
      3'd1: return {24'd0, 4'(mPres), 2'b0, mSow, mCont};
      3'd2: return mPer[31:0];
      3'd3: return mPer[63:32];
      3'd4: return mCnt[31:0];
      3'd5: return mShadow;
      3'd6: return {31'd0, mFlag};
      3'd7: return {31'd0, mEn};
      default: return 32'd0;
    endcase
  endfunction

  // R11: irq compared on every clock
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (irqOut !== (mFlag && mEn)) begin
        fails++;
        $display("FAIL R11 irqOut actual %0b expected %0b at %0t", irqOut, mFlag && mEn, $time);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    busRe = 1; busAddr = a;
    #1;
    exp = modelRead(a);
    checks++;
    if (busRdata !== exp) begin
      fails++;
      $display("FAIL %s read word %0d actual %h expected %h", tag, a, busRdata, exp);
    end
    @(negedge clk);
    busRe = 0;
  endtask

  task automatic chk(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    chk(irqOut == 0, "R1 irq", {31'd0, irqOut}, 0);

    // R2 R4 continuous, period 3, prescale 0
    wr(7, 1);
    wr(2, 3);
    wr(1, 32'h1);
    wr(0, 1);
    rd(4, "R2");
    rd(4, "R2");
    idle(3);
    rd(4, "R4");
    rd(6, "R4");
    rd(6, "R10");
    idle(6);
    rd(6, "R4");

    // R3 prescale 2
    wr(1, 32'h21);
    wr(0, 1);
    for (int i = 0; i < 6; i++) rd(4, "R3");
    idle(10);
    rd(6, "R3");

    // R5 one-shot, period 1
    wr(1, 32'h0);
    wr(2, 1);
    wr(0, 1);
    idle(6);
    rd(6, "R5");
    rd(4, "R5");
    rd(4, "R5");
    wr(0, 1);
    rd(4, "R5");
    idle(4);
    rd(6, "R5");

    // R11 masked flag still sets
    wr(7, 0);
    wr(0, 1);
    idle(5);
    chk(irqOut == 0, "R11 masked", {31'd0, irqOut}, 0);
    rd(6, "R11");
    wr(7, 1);

    // R8 period writes with start-on-write clear only store
    wr(3, 0); wr(2, 32'h20);
    idle(3);
    rd(4, "R8");
    rd(2, "R8");
    rd(6, "R8");

    // R7 count writes ignored with start-on-write clear
    wr(1, 32'h1);
    wr(0, 1);
    wr(4, 32'h1c);
    rd(4, "R7");

    // R6 R12 start-on-write, short period, hi then lo then start
    wr(1, 32'h2);
    wr(3, 0);
    rd(4, "R6");
    wr(2, 0);
    idle(3);
    rd(6, "R12");
    wr(0, 1);
    idle(3);
    rd(6, "R12");

    // R7 loads while running; R9 shadow across a carry
    wr(1, 32'h3);
    wr(3, 32'h10);
    wr(2, 0);
    wr(5, 32'h5);
    wr(4, 32'hffff_fffe);
    rd(4, "R9");
    rd(5, "R9");
    rd(4, "R9");
    rd(5, "R9");
    chk(busRdata == 32'h6, "R9 carry", busRdata, 32'h6);
    wr(1, 32'h0);
    idle(2);
    wr(4, 32'h77);
    rd(4, "R7");

    // R10 read on a matching cycle keeps flag set (period 0, continuous)
    wr(1, 32'h1);
    wr(3, 0);
    wr(2, 0);
    wr(0, 1);
    idle(2);
    rd(6, "R10");
    rd(6, "R10");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule